// File: doc/BRIEF.md
# Translation Mode Index Generator

This block turns a machine state word into the two small context numbers that an address-translation front end uses to pick its lookup context: one for instruction fetches and one for data accesses. Each number is three bits wide. The block also produces a handful of derived execution flags, such as endianness, user mode, data relocation, floating-point enable, single-step, branch-trace and hypervisor privilege, which the fetch and decode logic consume.

Two encodings of the context numbers are supported. A static mode input selects between them. The server encoding keys on hypervisor state and on whether relocation is off. The embedded encoding keys on guest state and on the address-space selectors. Indices and flags are captured in registers one cycle after a load strobe and hold their value until the next strobe. A mismatch output compares the captured values against a fresh evaluation of the present inputs. This catches a state word that changed without the result being reloaded.

Top module: `xlat_ctx_gen`

## Requirements
- R1: A synchronous active-high reset clears both indices, all flag bits and the stored state. Reset takes priority over the load strobe.
- R2: Indices and flags change only on the clock edge that samples `load` high, and they show the new result from the following cycle. With `load` low they hold their value whatever the inputs do.
- R3: Bit 0 of both indices is 1 (kernel) when state bit 1 (user mode) is 0, and 0 when that bit is 1.
- R4: With `embedded_mode` = 0 (server encoding), bit 2 of both indices equals state bit 8 (hypervisor state). Instruction index bit 1 is the inverse of state bit 4 (instruction relocate). Data index bit 1 is the inverse of state bit 2 (data relocate).
- R5: With `embedded_mode` = 1 (embedded encoding), bit 2 of both indices equals state bit 9 (guest state). Instruction index bit 1 equals state bit 10 (instruction address space). Data index bit 1 equals state bit 11 (data address space).
- R6: Flag bit 6 (hypervisor) is 1 when `hv_capable` is 0, or when state bit 8 is 1.
- R7: With `dbg_cfg_en` = 1, flag bit 4 (single-step) equals `dbg_icmp` AND state bit 7 (debug enable). Flag bit 5 (branch trace) equals `dbg_brt` AND state bit 7.
- R8: With `dbg_cfg_en` = 0, flag bit 4 equals state bit 5 and flag bit 5 equals state bit 6. The debug control inputs have no effect on either flag.
- R9: Flag bits 3..0 copy state bits 3..0 unchanged: floating-point available, data relocate, user mode and little-endian, from bit 3 down to bit 0.
- R10: `mismatch` is 1 exactly when the stored indices or flags differ from the values the current inputs would produce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for indices and flags |
| embedded_mode | input | 1 | Static encoding select: 0 server, 1 embedded |
| hv_capable | input | 1 | Strap: core implements a hypervisor mode |
| dbg_cfg_en | input | 1 | Configuration: debug-control gating of trace flags |
| dbg_icmp | input | 1 | Debug control: instruction-compare enable |
| dbg_brt | input | 1 | Debug control: branch-taken trace enable |
| state_word | input | 32 | Machine state word |
| imode_idx | output | 3 | Registered instruction-side context index |
| dmode_idx | output | 3 | Registered data-side context index |
| flags | output | 7 | Registered execution flags |
| mismatch | output | 1 | Stored result differs from fresh evaluation |

## Verification
A corrupted stored index or flag shows on the output ports in the first cycle after the load edge. In that same cycle `mismatch` rises, provided the inputs are unchanged. A capture register that misses a strobe, or that updates without one, shows as a held or changed value one cycle later. The reference model tracks this every cycle. Faults in the encoding select or in the debug gating show only under the matching mode and configuration, so both encodings and both debug settings are run with mixed state words.

// File: rtl/xlat_ctx_pkg.sv
package xlat_ctx_pkg;

    localparam int STATE_W = 32;
    localparam int IDX_W   = 3;
    localparam int FLAG_W  = 7;

    // state word bit positions
    localparam int ST_LE = 0;
    localparam int ST_PR = 1;
    localparam int ST_DR = 2;
    localparam int ST_FP = 3;
    localparam int ST_IR = 4;
    localparam int ST_SE = 5;
    localparam int ST_BE = 6;
    localparam int ST_DE = 7;
    localparam int ST_HV = 8;
    localparam int ST_GS = 9;
    localparam int ST_IS = 10;
    localparam int ST_DS = 11;

    // index bit positions
    localparam int IX_KERN = 0;
    localparam int IX_SPC  = 1;
    localparam int IX_CTX  = 2;

    typedef enum logic {
        ENC_SERVER = 1'b0,
        ENC_EMBED  = 1'b1
    } enc_e;

    typedef struct packed {
        logic [IDX_W-1:0] iidx;
        logic [IDX_W-1:0] didx;
    } ctx_pair_t;

    // packed from msb to lsb: bit 0 is le
    typedef struct packed {
        logic hv;
        logic btrace;
        logic sstep;
        logic fp;
        logic dr;
        logic pr;
        logic le;
    } xflags_t;

    function automatic logic kern_bit(input logic user_mode);
        return ~user_mode;
    endfunction

endpackage

// File: rtl/xlat_idx_gen.sv
module xlat_idx_gen
    import xlat_ctx_pkg::*;
#(
    parameter int SW = STATE_W
) (
    input  logic [SW-1:0] state,
    input  enc_e          enc,
    output ctx_pair_t     ctx
);
    localparam int NENC = 2;

    logic [IDX_W-1:0] iidx_v [NENC];
    logic [IDX_W-1:0] didx_v [NENC];

    for (genvar e = 0; e < NENC; e++) begin : g_enc
        always_comb begin
            iidx_v[e]          = '0;
            didx_v[e]          = '0;
            iidx_v[e][IX_KERN] = kern_bit(state[ST_PR]);
            didx_v[e][IX_KERN] = kern_bit(state[ST_PR]);
            if (e == int'(ENC_SERVER)) begin
                iidx_v[e][IX_CTX] = state[ST_HV];
                didx_v[e][IX_CTX] = state[ST_HV];
                iidx_v[e][IX_SPC] = ~state[ST_IR];
                didx_v[e][IX_SPC] = ~state[ST_DR];
            end else begin
                iidx_v[e][IX_CTX] = state[ST_GS];
                didx_v[e][IX_CTX] = state[ST_GS];
                iidx_v[e][IX_SPC] = state[ST_IS];
                didx_v[e][IX_SPC] = state[ST_DS];
            end
        end
    end

    always_comb begin
        ctx.iidx = iidx_v[int'(enc)];
        ctx.didx = didx_v[int'(enc)];
    end

endmodule

// File: rtl/xlat_flag_gen.sv
module xlat_flag_gen
    import xlat_ctx_pkg::*;
#(
    parameter int SW = STATE_W
) (
    input  logic [SW-1:0] state,
    input  logic          hv_capable,
    input  logic          dbg_cfg_en,
    input  logic          dbg_icmp,
    input  logic          dbg_brt,
    output xflags_t       fl
);
    always_comb begin
        fl.le = state[ST_LE];
        fl.pr = state[ST_PR];
        fl.dr = state[ST_DR];
        fl.fp = state[ST_FP];
        if (dbg_cfg_en) begin
            fl.sstep  = dbg_icmp & state[ST_DE];
            fl.btrace = dbg_brt  & state[ST_DE];
        end else begin
            fl.sstep  = state[ST_SE];
            fl.btrace = state[ST_BE];
        end
        fl.hv = ~hv_capable | state[ST_HV];
    end

endmodule

// File: rtl/xlat_ctx_store.sv
module xlat_ctx_store
    import xlat_ctx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  ctx_pair_t fresh_ctx,
    input  xflags_t   fresh_fl,
    output ctx_pair_t held_ctx,
    output xflags_t   held_fl,
    output logic      diff
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_ctx <= '0;
            held_fl  <= '0;
        end else if (load) begin
            held_ctx <= fresh_ctx;
            held_fl  <= fresh_fl;
        end
    end

    always_comb begin
        diff = (held_ctx != fresh_ctx) || (held_fl != fresh_fl);
    end

endmodule

// File: rtl/xlat_ctx_gen.sv
module xlat_ctx_gen
    import xlat_ctx_pkg::*;
#(
    parameter int SW = STATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              embedded_mode,
    input  logic              hv_capable,
    input  logic              dbg_cfg_en,
    input  logic              dbg_icmp,
    input  logic              dbg_brt,
    input  logic [SW-1:0]     state_word,
    output logic [IDX_W-1:0]  imode_idx,
    output logic [IDX_W-1:0]  dmode_idx,
    output logic [FLAG_W-1:0] flags,
    output logic              mismatch
);
    enc_e      enc;
    ctx_pair_t fresh_ctx;
    ctx_pair_t held_ctx;
    xflags_t   fresh_fl;
    xflags_t   held_fl;

    assign enc = enc_e'(embedded_mode);

    xlat_idx_gen #(.SW(SW)) u_idx (
        .state (state_word),
        .enc   (enc),
        .ctx   (fresh_ctx)
    );

    xlat_flag_gen #(.SW(SW)) u_flag (
        .state      (state_word),
        .hv_capable (hv_capable),
        .dbg_cfg_en (dbg_cfg_en),
        .dbg_icmp   (dbg_icmp),
        .dbg_brt    (dbg_brt),
        .fl         (fresh_fl)
    );

    xlat_ctx_store u_store (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .fresh_ctx (fresh_ctx),
        .fresh_fl  (fresh_fl),
        .held_ctx  (held_ctx),
        .held_fl   (held_fl),
        .diff      (mismatch)
    );

    assign imode_idx = held_ctx.iidx;
    assign dmode_idx = held_ctx.didx;
    assign flags     = held_fl;

endmodule

// File: rtl/xlat_ctx_gen_chk.sv
module xlat_ctx_gen_chk
    import xlat_ctx_pkg::*;
#(
    parameter int SW = STATE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic              embedded_mode,
    input logic              hv_capable,
    input logic              dbg_cfg_en,
    input logic              dbg_icmp,
    input logic              dbg_brt,
    input logic [SW-1:0]     state_word,
    input logic [IDX_W-1:0]  imode_idx,
    input logic [IDX_W-1:0]  dmode_idx,
    input logic [FLAG_W-1:0] flags,
    input logic              mismatch
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (imode_idx == '0 && dmode_idx == '0 && flags == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(imode_idx) && $stable(dmode_idx) && $stable(flags)));

    p_kern_bit_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (imode_idx[IX_KERN] == !$past(state_word[ST_PR])
              && dmode_idx[IX_KERN] == !$past(state_word[ST_PR])));

    p_server_enc_r4: assert property (@(posedge clk) disable iff (rst)
        (load && !embedded_mode) |=>
            (imode_idx[IX_CTX] == $past(state_word[ST_HV])
          && dmode_idx[IX_CTX] == $past(state_word[ST_HV])
          && imode_idx[IX_SPC] == !$past(state_word[ST_IR])
          && dmode_idx[IX_SPC] == !$past(state_word[ST_DR])));

    p_embed_enc_r5: assert property (@(posedge clk) disable iff (rst)
        (load && embedded_mode) |=>
            (imode_idx[IX_CTX] == $past(state_word[ST_GS])
          && dmode_idx[IX_CTX] == $past(state_word[ST_GS])
          && imode_idx[IX_SPC] == $past(state_word[ST_IS])
          && dmode_idx[IX_SPC] == $past(state_word[ST_DS])));

    p_hv_flag_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> (flags[6] == (!$past(hv_capable) || $past(state_word[ST_HV]))));

    p_dbg_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (load && dbg_cfg_en) |=>
            (flags[4] == ($past(dbg_icmp) && $past(state_word[ST_DE]))
          && flags[5] == ($past(dbg_brt) && $past(state_word[ST_DE]))));

    p_dbg_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (load && !dbg_cfg_en) |=>
            (flags[4] == $past(state_word[ST_SE])
          && flags[5] == $past(state_word[ST_BE])));

    p_straight_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> (flags[3:0] == $past(state_word[3:0])));

    p_consistent_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> (!($stable(state_word) && $stable(embedded_mode)
                 && $stable(hv_capable) && $stable(dbg_cfg_en)
                 && $stable(dbg_icmp) && $stable(dbg_brt)) || !mismatch));

endmodule

bind xlat_ctx_gen xlat_ctx_gen_chk #(.SW(SW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .load          (load),
    .embedded_mode (embedded_mode),
    .hv_capable    (hv_capable),
    .dbg_cfg_en    (dbg_cfg_en),
    .dbg_icmp      (dbg_icmp),
    .dbg_brt       (dbg_brt),
    .state_word    (state_word),
    .imode_idx     (imode_idx),
    .dmode_idx     (dmode_idx),
    .flags         (flags),
    .mismatch      (mismatch)
);

// File: tb/xlat_ctx_gen_bench.sv
`timescale 1ns/1ps
module xlat_ctx_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic        embedded_mode = 1'b0;
    logic        hv_capable = 1'b1;
    logic        dbg_cfg_en = 1'b0;
    logic        dbg_icmp = 1'b0;
    logic        dbg_brt = 1'b0;
    logic [31:0] state_word = '0;
    logic [2:0]  imode_idx;
    logic [2:0]  dmode_idx;
    logic [6:0]  flags;
    logic        mismatch;

    int total = 0;
    int bad   = 0;
    bit checking = 0;
    bit finished = 0;
    int seed = 32'h5eed_1234;

    always #5 clk = ~clk;

    xlat_ctx_gen u_xlat_ctx_gen (
        .clk           (clk),
        .rst           (rst),
        .load          (load),
        .embedded_mode (embedded_mode),
        .hv_capable    (hv_capable),
        .dbg_cfg_en    (dbg_cfg_en),
        .dbg_icmp      (dbg_icmp),
        .dbg_brt       (dbg_brt),
        .state_word    (state_word),
        .imode_idx     (imode_idx),
        .dmode_idx     (dmode_idx),
        .flags         (flags),
        .mismatch      (mismatch)
    );

    // reference results, computed from the requirement text
    function automatic logic [2:0] ref_idx(input logic [31:0] s, input logic emb,
                                           input logic instr);
        logic [2:0] r;
        r[0] = (s[1] == 1'b0);
        if (!emb) begin
            r[2] = s[8];
            r[1] = instr ? (s[4] == 1'b0) : (s[2] == 1'b0);
        end else begin
            r[2] = s[9];
            r[1] = instr ? s[10] : s[11];
        end
        return r;
    endfunction

    function automatic logic [6:0] ref_flags(input logic [31:0] s, input logic hvc,
                                             input logic dbe, input logic ic,
                                             input logic br);
        logic [6:0] f;
        f[3:0] = s[3:0];
        if (dbe) begin
            f[4] = ic && s[7];
            f[5] = br && s[7];
        end else begin
            f[4] = s[5];
            f[5] = s[6];
        end
        f[6] = (!hvc) || s[8];
        return f;
    endfunction

    logic [2:0] m_i, m_d;
    logic [6:0] m_f;
    bit         m_held;
    bit         m_dbg;
    bit         m_rst;

    always @(posedge clk) begin
        if (rst) begin
            m_i <= '0; m_d <= '0; m_f <= '0; m_held <= 0; m_rst <= 1;
        end else if (load) begin
            m_i    <= ref_idx(state_word, embedded_mode, 1'b1);
            m_d    <= ref_idx(state_word, embedded_mode, 1'b0);
            m_f    <= ref_flags(state_word, hv_capable, dbg_cfg_en, dbg_icmp, dbg_brt);
            m_dbg  <= dbg_cfg_en;
            m_held <= 0;
            m_rst  <= 0;
        end else begin
            m_held <= 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking && !finished) begin
            logic [2:0] fi, fd;
            logic [6:0] ff;
            bit exp_mis;
            if (m_rst) begin
                check("R1 reset indices", {imode_idx, dmode_idx}, 0);
                check("R1 reset flags", flags, 0);
            end else if (m_held) begin
                check("R2 held instr index", imode_idx, m_i);
                check("R2 held data index", dmode_idx, m_d);
                check("R2 held flags", flags, m_f);
            end else begin
                check("R3 kernel bit instr", imode_idx[0], m_i[0]);
                check("R3 kernel bit data", dmode_idx[0], m_d[0]);
                if (embedded_mode) begin
                    check("R5 embedded indices", {imode_idx[2:1], dmode_idx[2:1]},
                          {m_i[2:1], m_d[2:1]});
                end else begin
                    check("R4 server indices", {imode_idx[2:1], dmode_idx[2:1]},
                          {m_i[2:1], m_d[2:1]});
                end
                if (m_dbg) check("R7 gated trace flags", flags[5:4], m_f[5:4]);
                else       check("R8 passed trace flags", flags[5:4], m_f[5:4]);
                check("R6 hypervisor flag", flags[6], m_f[6]);
                check("R9 straight flags", flags[3:0], m_f[3:0]);
            end
            fi = ref_idx(state_word, embedded_mode, 1'b1);
            fd = ref_idx(state_word, embedded_mode, 1'b0);
            ff = ref_flags(state_word, hv_capable, dbg_cfg_en, dbg_icmp, dbg_brt);
            exp_mis = (fi != m_i) || (fd != m_d) || (ff != m_f);
            check("R10 mismatch", mismatch, exp_mis);
        end
    end

    task automatic drive_random(input bit do_load);
        @(posedge clk);
        #1;
        state_word = $random(seed);
        dbg_icmp   = $random(seed);
        dbg_brt    = $random(seed);
        dbg_cfg_en = $random(seed);
        hv_capable = $random(seed);
        load       = do_load;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst  = 1'b1;
        load = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst  = 1'b0;
        load = 1'b0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        checking = 1;
        #1;
        rst = 1'b0;

        for (int ph = 0; ph < 2; ph++) begin
            do_reset();
            embedded_mode = ph[0];
            // directed corners: all-zero and all-one words, both debug settings
            for (int k = 0; k < 4; k++) begin
                @(posedge clk);
                #1;
                state_word = k[0] ? 32'hFFFF_FFFF : 32'h0;
                dbg_cfg_en = k[1];
                dbg_icmp   = 1'b1;
                dbg_brt    = 1'b0;
                hv_capable = k[0];
                load       = 1'b1;
            end
            // R8: debug controls toggled alone with debug gating off
            @(posedge clk);
            #1;
            state_word = 32'h0000_0060;
            dbg_cfg_en = 1'b0;
            dbg_icmp   = 1'b0;
            dbg_brt    = 1'b1;
            load       = 1'b1;
            // R2/R10: inputs change while load stays low
            drive_random(1'b1);
            drive_random(1'b0);
            drive_random(1'b0);
            drive_random(1'b0);
            for (int n = 0; n < 400; n++) begin
                drive_random(($random(seed) & 3) != 0);
            end
        end
        // reset with load high: reset wins (R1)
        do_reset();
        @(posedge clk);
        #1;
        load = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule